// File: doc/BRIEF.md
# Keyed Refresh Interval Timer

This block paces memory refresh. A programmable prescaler divides the core clock by one of seven ratios. Each prescaled tick advances an 8-bit interval counter. When the counter reaches a programmable compare value, the block does three things: it raises a one-cycle refresh request, it sets a sticky match flag, and on the following tick it returns the counter to zero. The interval is therefore bounded by the 8-bit compare range. A memory controller consumes the request pulse and sequences the refresh command itself.

Software sees three word registers: control, count and compare. A write changes a register only when the upper half of the 32-bit write word carries a fixed key. Stray or partial stores therefore cannot alter the refresh rate. Reads need no key.

The interval logic is a two-state machine. RUN counts ticks. On the tick that brings the counter to the compare value, the transition MATCH moves it to WRAP. In WRAP the next tick clears the counter, and the transition RESTART returns it to RUN. A software write to the count register takes the transition RELOAD, which goes from either state to RUN.

Top module: `refresh_timer`

## Requirements
- R1: A write changes a register only when bus_wdata[31:16] equals 16'hA55A. Any other value leaves every register unchanged.
- R2: The control register is at byte offset 0x0, count at 0x4 and compare at 0x8. A read returns the register in bits 7:0 with bits 31:8 zero, and needs no key. Offset 0xC reads zero, and a keyed write to it changes nothing.
- R3: Control bits 5:3 hold the clock-select code and bit 7 holds the match flag. All other control bits read zero. Code 0 halts the prescaler, and the count then holds its value.
- R4: Codes 1 to 7 make the count advance once every 4, 16, 64, 256, 1024, 2048 and 4096 clock cycles respectively.
- R5: A keyed write that changes the clock-select code restarts the divider. The first advance happens exactly one full divisor of cycles after the write's clock edge.
- R6: The advance that brings the count to the compare value sets the match flag and raises refresh_req for exactly one cycle, both at that same edge.
- R7: The counter stays at the compare value until the next advance, which sets it to 0 instead of incrementing it.
- R8: A keyed control write with bit 7 at 0 clears the match flag. Writing 1 to bit 7 never sets it.
- R9: A keyed write to the count register loads bits 7:0 and cancels a pending return to zero, so the next advance increments the loaded value.
- R10: After reset, control reads 0x00, count reads 0x00, compare reads 0xFF and refresh_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write word: key in 31:16, value in 7:0 |
| bus_rdata | output | 32 | Read data for bus_addr, zero-extended |
| refresh_req | output | 1 | One-cycle refresh request on compare match |

## Verification
The assertions assume the following about the inputs:
- Reset is held low for at least one clock edge before the first check.
- bus_wr_en, bus_addr and bus_wdata carry known values at every clock edge.
- A write lasts exactly one cycle.

The stimulus drives every input shortly after a rising edge and holds each strobe for a single cycle. It keeps the data word at zero between writes and never leaves an input unknown after reset. Counter checks are timed against the landing edge of the write that started the divider, so each expected value follows from the divisor alone.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int          SEL_W  = 3;
    localparam int          PRE_W  = 12;
    localparam logic [15:0] WR_KEY = 16'hA55A;

    typedef enum logic {
        ST_RUN,
        ST_WRAP
    } iv_state_e;

    // Terminal value of the divider for each clock-select code (divisor - 1).
    function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] code);
        logic [PRE_W-1:0] r;
        case (code)
            3'd1:    r = PRE_W'(3);
            3'd2:    r = PRE_W'(15);
            3'd3:    r = PRE_W'(63);
            3'd4:    r = PRE_W'(255);
            3'd5:    r = PRE_W'(1023);
            3'd6:    r = PRE_W'(2047);
            3'd7:    r = PRE_W'(4095);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rt_bus_guard.sv
module rt_bus_guard #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       key_field,
    output logic              ctrl_we,
    output logic              cnt_we,
    output logic              cmp_we
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_CMP  = ADDR_W'(8);

    logic key_ok;

    assign key_ok  = wr_en && (key_field == rt_pkg::WR_KEY);
    assign ctrl_we = key_ok && (addr == OFS_CTRL);
    assign cnt_we  = key_ok && (addr == OFS_CNT);
    assign cmp_we  = key_ok && (addr == OFS_CMP);

endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler
    import rt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic             sel_change;

    assign sel_change = sel_we && (sel_wdata != sel_q);
    assign tick       = (sel_q != '0) && (pre_q == div_last(sel_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            pre_q <= '0;
        end else if (sel_change) begin
            sel_q <= sel_wdata;
            pre_q <= '0;
        end else if (sel_q == '0 || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R5: a code change always starts a fresh period, so no tick follows it directly
    a_r5_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change |=> !tick);

    // R4: the smallest divisor is 4, so ticks are never adjacent
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: a halted prescaler stays silent while the code remains zero
    a_r3_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0 && !sel_we) |=> !tick);

endmodule

// File: rtl/rt_interval.sv
module rt_interval
    import rt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_wbit,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q,
    output logic             refresh_req
);
    iv_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_inc;
    logic             match;

    assign count_inc = count_q + CNT_W'(1);
    assign match     = (state_q == ST_RUN) && tick && !cnt_we && (count_inc == cmp_q);

    // Next state: MATCH (RUN->WRAP), RESTART (WRAP->RUN), RELOAD (any->RUN)
    always_comb begin
        state_d = state_q;
        if (cnt_we) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:  if (match) state_d = ST_WRAP;
                ST_WRAP: if (tick)  state_d = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q     <= '0;
            cmp_q       <= '1;
            flag_q      <= 1'b0;
            refresh_req <= 1'b0;
        end else begin
            refresh_req <= match;
            if (cmp_we) cmp_q <= wdata;
            if (cnt_we) begin
                count_q <= wdata;
            end else if (tick) begin
                count_q <= (state_q == ST_WRAP) ? '0 : count_inc;
            end
            if (match)                       flag_q <= 1'b1;
            else if (ctrl_we && !flag_wbit)  flag_q <= 1'b0;
        end
    end

    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);

    a_r6_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> flag_q);

    a_r6_req_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (count_q == cmp_q));

    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && tick && !cnt_we) |=> (count_q == '0));

    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(count_q));

    a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_q == $past(wdata)));

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !flag_wbit && !refresh_req && !match) |=> !flag_q);

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              refresh_req
);
    import rt_pkg::*;

    localparam int SEL_LO = 3;
    localparam int FLAG_B = 7;

    logic             ctrl_we, cnt_we, cmp_we;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic [CNT_W-1:0] count_q, cmp_q;
    logic             flag_q;
    logic [7:0]       ctrl_view;
    logic             wr_unused;

    assign wr_unused = ^bus_wdata[15:8];

    rt_bus_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .key_field (bus_wdata[DATA_W-1:DATA_W-16]),
        .ctrl_we   (ctrl_we),
        .cnt_we    (cnt_we),
        .cmp_we    (cmp_we)
    );

    rt_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (ctrl_we),
        .sel_wdata (bus_wdata[SEL_LO+SEL_W-1:SEL_LO]),
        .sel_q     (sel_q),
        .tick      (tick)
    );

    rt_interval #(.CNT_W(CNT_W)) u_iv (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cnt_we      (cnt_we),
        .cmp_we      (cmp_we),
        .ctrl_we     (ctrl_we),
        .wdata       (bus_wdata[CNT_W-1:0]),
        .flag_wbit   (bus_wdata[FLAG_B]),
        .count_q     (count_q),
        .cmp_q       (cmp_q),
        .flag_q      (flag_q),
        .refresh_req (refresh_req)
    );

    assign ctrl_view = {flag_q, 1'b0, sel_q, 3'b000};

    always_comb begin
        case (bus_addr)
            ADDR_W'(0): bus_rdata = DATA_W'(ctrl_view);
            ADDR_W'(4): bus_rdata = DATA_W'(count_q);
            ADDR_W'(8): bus_rdata = DATA_W'(cmp_q);
            default:    bus_rdata = '0;
        endcase
    end

    a_r1_strobe_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we || cnt_we || cmp_we) |-> (bus_wdata[DATA_W-1:DATA_W-16] == WR_KEY));

    a_r1_unkeyed_cmp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_wdata[DATA_W-1:DATA_W-16] != WR_KEY) |=> $stable(cmp_q));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:8] == '0);

endmodule

// File: tb/refresh_timer_bench.sv
module refresh_timer_bench;

    localparam logic [3:0]  A_CTRL = 4'h0;
    localparam logic [3:0]  A_CNT  = 4'h4;
    localparam logic [3:0]  A_CMP  = 4'h8;
    localparam logic [3:0]  A_NONE = 4'hC;
    localparam logic [31:0] KEY    = 32'hA55A_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        refresh_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_timer u_refresh_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .refresh_req (refresh_req)
    );

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] exp;
        int          exp_req;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        sb_item_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s: rdata[%h] actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
            end
            if (it.exp_req >= 0) begin
                checks++;
                if (refresh_req !== 1'(it.exp_req)) begin
                    failures++;
                    $display("FAIL %s: refresh_req actual %b expected %0d", it.tag, refresh_req, it.exp_req);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int land);
        @(posedge clk); #1;
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        land = cyc;
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input int r, input string tag);
        sb_item_t it;
        bus_addr = a;
        it.addr = a; it.exp = e; it.exp_req = r; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic at_cycle(input int c);
        while (cyc < c) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run actual still busy expected finished");
            finish_run();
        end
    end

    initial begin
        int l, m, n, l2;
        rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state, R2 empty offset
        expect_rd(A_CTRL, 32'h0, 0, "R10 ctrl reset");
        expect_rd(A_CNT, 32'h0, 0, "R10 count reset");
        expect_rd(A_CMP, 32'hFF, 0, "R10 compare reset");
        expect_rd(A_NONE, 32'h0, 0, "R2 offset 0xC reads zero");

        // R1 unkeyed writes are dropped
        wr(A_CMP, 32'h1234_0005, l);
        expect_rd(A_CMP, 32'hFF, -1, "R1 unkeyed compare write");
        wr(A_CTRL, 32'h0000_0008, l);
        expect_rd(A_CTRL, 32'h0, -1, "R1 unkeyed ctrl write");
        wr(A_CNT, 32'hA55B_0033, l);
        expect_rd(A_CNT, 32'h0, -1, "R1 near-miss key");

        // R2 keyed write, upper read bits zero
        wr(A_CMP, KEY | 32'h0000_FF02, l);
        expect_rd(A_CMP, 32'h02, -1, "R2 compare readback");

        // Divide by 4 with compare 2
        wr(A_CTRL, KEY | 32'h08, l);
        expect_rd(A_CTRL, 32'h08, 0, "R3 select field");
        at_cycle(l + 3);
        expect_rd(A_CNT, 32'h0, 0, "R5 no advance before full period");
        at_cycle(l + 4);
        expect_rd(A_CNT, 32'h1, 0, "R4 divide by 4");
        at_cycle(l + 8);
        expect_rd(A_CTRL, 32'h88, 1, "R6 match flag and request");
        at_cycle(l + 9);
        expect_rd(A_CNT, 32'h2, 0, "R6 request lasts one cycle");
        at_cycle(l + 11);
        expect_rd(A_CNT, 32'h2, 0, "R7 holds at compare");
        at_cycle(l + 12);
        expect_rd(A_CNT, 32'h0, 0, "R7 returns to zero");
        at_cycle(l + 16);
        expect_rd(A_CNT, 32'h1, 0, "R7 counts again");

        // R3 halt (write lands at l+18, count 1), flag kept by bit7 = 1
        wr(A_CTRL, KEY | 32'h80, m);
        expect_rd(A_CTRL, 32'h80, 0, "R3 halted, flag kept");
        at_cycle(m + 50);
        expect_rd(A_CNT, 32'h1, 0, "R3 count holds while halted");

        // R1 / R8 flag clearing
        wr(A_CTRL, 32'h0000_0000, l);
        expect_rd(A_CTRL, 32'h80, -1, "R1 unkeyed clear ignored");
        wr(A_CTRL, KEY, l);
        expect_rd(A_CTRL, 32'h00, -1, "R8 keyed clear");
        wr(A_CTRL, KEY | 32'h80, l);
        expect_rd(A_CTRL, 32'h00, -1, "R8 writing one does not set");

        // R9 reload cancels pending wrap
        wr(A_CNT, KEY, l);
        wr(A_CTRL, KEY | 32'h08, l);
        at_cycle(l + 8);
        expect_rd(A_CTRL, 32'h88, 1, "R6 second run match");
        wr(A_CNT, KEY | 32'h10, n);
        expect_rd(A_CNT, 32'h10, -1, "R9 load value");
        at_cycle(n + 2);
        expect_rd(A_CNT, 32'h11, -1, "R9 increments after reload");
        wr(A_CTRL, KEY, l);

        // R2 keyed write to empty offset changes nothing
        wr(A_NONE, KEY | 32'h77, l);
        expect_rd(A_NONE, 32'h0, -1, "R2 offset 0xC stays zero");
        expect_rd(A_CNT, 32'h11, -1, "R2 count untouched");
        expect_rd(A_CMP, 32'h02, -1, "R2 compare untouched");
        expect_rd(A_CTRL, 32'h00, -1, "R2 ctrl untouched");

        // R4 / R5 every divisor
        wr(A_CMP, KEY | 32'hFF, l);
        for (int code = 1; code <= 7; code++) begin
            int d;
            d = (code <= 5) ? (1 << (2 * code)) : ((code == 6) ? 2048 : 4096);
            wr(A_CTRL, KEY, l);
            wr(A_CNT, KEY, l);
            wr(A_CTRL, KEY | 32'(code << 3), l);
            at_cycle(l + d - 1);
            expect_rd(A_CNT, 32'h0, 0, $sformatf("R5 code %0d before period", code));
            at_cycle(l + d);
            expect_rd(A_CNT, 32'h1, 0, $sformatf("R4 code %0d divisor %0d", code, d));
        end

        // R5 mid-period code change restarts the divider
        wr(A_CTRL, KEY, l);
        wr(A_CNT, KEY, l);
        wr(A_CTRL, KEY | 32'h10, l);
        at_cycle(l + 10);
        wr(A_CTRL, KEY | 32'h18, l2);
        expect_rd(A_CNT, 32'h0, -1, "R5 no advance at change");
        at_cycle(l2 + 63);
        expect_rd(A_CNT, 32'h0, -1, "R5 restarted period not over");
        at_cycle(l2 + 64);
        expect_rd(A_CNT, 32'h1, -1, "R5 advance after full period");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule